// File: doc/BRIEF.md
# Ethernet Frame Length Policer

This block sits beside the receive and transmit byte streams of an Ethernet MAC and enforces a maximum frame length on each of them. Each direction carries its own byte counter. The counter runs from the first beat of a frame through the beat flagged last. The limit that applies to a frame depends on the direction and on two mode bits in a configuration word. With jumbo operation on, both directions use a programmable jumbo length. That length is clamped to a build-time ceiling.

Every input beat reappears on the output one clock later. A receive frame that is too long is forwarded in full, and its last beat carries a drop flag so that the next stage discards it. A transmit frame that is too long stops being assembled. Once the limit is exceeded, no further bytes are forwarded. The last beat still goes out, carrying the drop flag, so that the downstream framing closes.

In both directions the first overflowing byte sets a sticky error bit. Software clears that bit by writing 1 to it, and it also drives an interrupt output. A small register port holds the configuration word, the jumbo length and the status word.

Top module: `frame_len_policer`

## Requirements
- R1: With the jumbo bit (configuration bit 3) clear, the transmit limit is 1518 bytes whatever the value of configuration bit 8.
- R2: With the jumbo bit clear, the receive limit is 1538 bytes when configuration bit 8 is set, and 1518 bytes otherwise.
- R3: With the jumbo bit set, both directions use the jumbo length register as the limit. When that register holds a value above the build-time ceiling JUMBO_CEIL (default 10240), the ceiling is used instead.
- R4: The jumbo length register sits at byte address 0x48 and keeps only the low 14 bits of a write. It reads back zero-extended and resets to JUMBO_CEIL. The configuration word is at address 0x00 and the status word at address 0x24. All registers reset to 0 except the jumbo length register.
- R5: Frame length counts every beat from the first beat through the beat marked last. A frame whose length equals the limit passes; only a length strictly greater than the limit is flagged. Every receive beat appears on the receive output exactly one clock after it is presented.
- R6: On transmit, a beat that takes the length past the limit is not forwarded, and neither is any later beat of that frame, except the last beat. The last beat is always forwarded, one clock later, with the drop flag set. An overlong transmit frame therefore yields limit+1 output beats.
- R7: The first overflowing beat of a frame, in either direction, sets status bit 6 and the err_irq output. Both stay set until a register write to the status word with bit 6 = 1. A write with bit 6 = 0 leaves them unchanged, and a new error arriving in the same cycle as a clear wins over the clear.
- R8: The limit is captured on the first beat of each frame. A configuration write during a frame takes effect only from the next frame.
- R9: After a flagged frame, counting restarts at the next first beat, so a following frame within the limit passes without a drop flag.
- R10: The drop flag is asserted only on an output beat that is both valid and last. A frame that passes never carries it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| rx_in_valid | input | 1 | Receive beat valid |
| rx_in_last | input | 1 | Receive beat ends the frame |
| rx_in_data | input | 8 | Receive byte |
| rx_out_valid | output | 1 | Forwarded receive beat valid |
| rx_out_last | output | 1 | Forwarded receive beat is last |
| rx_out_data | output | 8 | Forwarded receive byte |
| rx_out_drop | output | 1 | Receive frame is overlong, discard it (last beat only) |
| tx_in_valid | input | 1 | Transmit beat valid |
| tx_in_last | input | 1 | Transmit beat ends the frame |
| tx_in_data | input | 8 | Transmit byte |
| tx_out_valid | output | 1 | Forwarded transmit beat valid |
| tx_out_last | output | 1 | Forwarded transmit beat is last |
| tx_out_data | output | 8 | Forwarded transmit byte |
| tx_out_drop | output | 1 | Transmit frame is overlong, assembly stopped (last beat only) |
| err_irq | output | 1 | Sticky length error interrupt (status bit 6) |

## Verification
On every cycle, the assertions check four things. The drop flag appears only on a valid last beat. Receive beats follow their inputs with one clock of latency, and a transmit last beat is never swallowed. The error bit stays set until it is cleared and rises after every overflow event. Each direction's captured limit holds still while a frame is in flight.

Some behaviour only the bench scenarios can show. These are the exact limit chosen for each combination of mode bits and direction, including the equal-versus-one-over boundary and the clamp of an oversized jumbo register. They also cover the number of transmit beats that survive truncation, the masking and reset value of the jumbo register, and the fact that a configuration change in mid-frame waits for the next frame.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int unsigned LEN_W  = 14;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h24;
  localparam logic [ADDR_W-1:0] ADDR_JMAX = 8'h48;

  localparam int unsigned CFG_JUMBO_BIT  = 3;
  localparam int unsigned CFG_RXEXT_BIT  = 8;
  localparam int unsigned STAT_ERR_BIT   = 6;

  localparam logic [CNT_W-1:0] STD_LIMIT    = 16'd1518;
  localparam logic [CNT_W-1:0] RX_EXT_LIMIT = 16'd1538;

  // Smaller of the programmed jumbo length and the build ceiling, widened.
  function automatic logic [CNT_W-1:0] clamp_len(input logic [LEN_W-1:0] prog,
                                                 input logic [LEN_W-1:0] ceil);
    logic [LEN_W-1:0] pick;
    pick = (prog > ceil) ? ceil : prog;
    return {{(CNT_W-LEN_W){1'b0}}, pick};
  endfunction

  // Limit for one frame given the mode bits and the direction.
  function automatic logic [CNT_W-1:0] pick_limit(input logic jumbo_en,
                                                  input logic ext_en,
                                                  input logic is_rx,
                                                  input logic [CNT_W-1:0] jumbo_eff);
    if (jumbo_en)             return jumbo_eff;
    else if (is_rx && ext_en) return RX_EXT_LIMIT;
    else                      return STD_LIMIT;
  endfunction

  // Saturating increment of a byte count.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] cnt);
    return (&cnt) ? cnt : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/flp_regs.sv
module flp_regs
  import flp_pkg::*;
#(
  parameter logic [LEN_W-1:0] CEIL = 14'd10240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              err_set,
  output logic              cfg_jumbo,
  output logic              cfg_rxext,
  output logic [CNT_W-1:0]  jumbo_eff,
  output logic              err,
  output logic              err_clr
);
  logic [WORD_W-1:0] cfg_q;
  logic [LEN_W-1:0]  jmax_q;
  logic              err_q;

  assign err_clr = wr_en && (addr == ADDR_STAT) && wdata[STAT_ERR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      jmax_q <= CEIL;
      err_q  <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_CFG)  cfg_q  <= wdata;
      if (wr_en && addr == ADDR_JMAX) jmax_q <= wdata[LEN_W-1:0];
      err_q <= err_set | (err_q & ~err_clr);
    end
  end

  assign cfg_jumbo = cfg_q[CFG_JUMBO_BIT];
  assign cfg_rxext = cfg_q[CFG_RXEXT_BIT];
  assign jumbo_eff = clamp_len(jmax_q, CEIL);
  assign err       = err_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CFG:  rdata = cfg_q;
      ADDR_JMAX: rdata = {{(WORD_W-LEN_W){1'b0}}, jmax_q};
      ADDR_STAT: rdata[STAT_ERR_BIT] = err_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/flp_guard.sv
module flp_guard
  import flp_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter bit          IS_RX    = 1'b1,
  parameter bit          TRUNCATE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_jumbo,
  input  logic              cfg_rxext,
  input  logic [CNT_W-1:0]  jumbo_eff,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data,
  output logic              out_drop,
  output logic              err_pulse,
  output logic              busy,
  output logic [CNT_W-1:0]  lim
);
  logic             busy_q, bad_q;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic             first, bad_prev, over_now, bad_nxt, fwd;
  logic [CNT_W-1:0] lim_now, cnt_nxt;

  assign first    = in_valid & ~busy_q;
  assign lim_now  = first ? pick_limit(cfg_jumbo, cfg_rxext, IS_RX, jumbo_eff) : lim_q;
  assign cnt_nxt  = first ? {{(CNT_W-1){1'b0}}, 1'b1} : sat_inc(cnt_q);
  assign bad_prev = first ? 1'b0 : bad_q;
  assign over_now = cnt_nxt > lim_now;
  assign bad_nxt  = bad_prev | over_now;
  assign err_pulse = in_valid & over_now & ~bad_prev;

  generate
    if (TRUNCATE) begin : g_trunc
      assign fwd = in_last | ~bad_nxt;
    end else begin : g_pass
      assign fwd = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      bad_q  <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else if (in_valid) begin
      busy_q <= ~in_last;
      lim_q  <= lim_now;
      cnt_q  <= in_last ? '0 : cnt_nxt;
      bad_q  <= in_last ? 1'b0 : bad_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
      out_drop  <= 1'b0;
    end else begin
      out_valid <= in_valid & fwd;
      out_last  <= in_valid & in_last;
      out_data  <= in_data;
      out_drop  <= in_valid & in_last & bad_nxt;
    end
  end

  assign busy = busy_q;
  assign lim  = lim_q;
endmodule

// File: rtl/frame_len_policer.sv
module frame_len_policer
  import flp_pkg::*;
#(
  parameter int unsigned JUMBO_CEIL = 10240,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_in_valid,
  input  logic              rx_in_last,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  output logic              rx_out_last,
  output logic [DATA_W-1:0] rx_out_data,
  output logic              rx_out_drop,
  input  logic              tx_in_valid,
  input  logic              tx_in_last,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  output logic              tx_out_last,
  output logic [DATA_W-1:0] tx_out_data,
  output logic              tx_out_drop,
  output logic              err_irq
);
  localparam int unsigned CEIL_MAX = (1 << LEN_W) - 1;
  localparam logic [LEN_W-1:0] CEIL_V =
    (JUMBO_CEIL > CEIL_MAX) ? LEN_W'(CEIL_MAX) : LEN_W'(JUMBO_CEIL);

  logic             cfg_jumbo, cfg_rxext, err_clr;
  logic [CNT_W-1:0] jumbo_eff;
  logic             rx_err_evt, tx_err_evt, err_set;
  logic             rx_busy, tx_busy;
  logic [CNT_W-1:0] rx_lim, tx_lim;

  assign err_set = rx_err_evt | tx_err_evt;

  flp_regs #(.CEIL(CEIL_V)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .err_set(err_set), .cfg_jumbo(cfg_jumbo), .cfg_rxext(cfg_rxext),
    .jumbo_eff(jumbo_eff), .err(err_irq), .err_clr(err_clr)
  );

  flp_guard #(.DATA_W(DATA_W), .IS_RX(1'b1), .TRUNCATE(1'b0)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cfg_jumbo(cfg_jumbo), .cfg_rxext(cfg_rxext), .jumbo_eff(jumbo_eff),
    .in_valid(rx_in_valid), .in_last(rx_in_last), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_last(rx_out_last), .out_data(rx_out_data),
    .out_drop(rx_out_drop), .err_pulse(rx_err_evt), .busy(rx_busy), .lim(rx_lim)
  );

  flp_guard #(.DATA_W(DATA_W), .IS_RX(1'b0), .TRUNCATE(1'b1)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cfg_jumbo(cfg_jumbo), .cfg_rxext(cfg_rxext), .jumbo_eff(jumbo_eff),
    .in_valid(tx_in_valid), .in_last(tx_in_last), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_last(tx_out_last), .out_data(tx_out_data),
    .out_drop(tx_out_drop), .err_pulse(tx_err_evt), .busy(tx_busy), .lim(tx_lim)
  );
endmodule

// File: rtl/flp_checker.sv
module flp_checker
  import flp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rx_in_valid,
  input logic             rx_in_last,
  input logic             rx_out_valid,
  input logic             rx_out_last,
  input logic             rx_out_drop,
  input logic             tx_in_valid,
  input logic             tx_in_last,
  input logic             tx_out_valid,
  input logic             tx_out_last,
  input logic             tx_out_drop,
  input logic             err_irq,
  input logic             err_set,
  input logic             err_clr,
  input logic             rx_busy,
  input logic             tx_busy,
  input logic [CNT_W-1:0] rx_lim,
  input logic [CNT_W-1:0] tx_lim
);
  AST_RX_DROP_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_drop |-> (rx_out_valid && rx_out_last)); // R10
  AST_TX_DROP_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_drop |-> (tx_out_valid && tx_out_last)); // R10
  AST_RX_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid |=> rx_out_valid); // R5
  AST_RX_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_in_valid |=> !rx_out_valid); // R5
  AST_TX_LAST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_in_valid && tx_in_last) |=> (tx_out_valid && tx_out_last)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !err_clr) |=> err_irq); // R7
  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_irq); // R7
  AST_RX_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !(rx_in_valid && rx_in_last)) |=> $stable(rx_lim)); // R8
  AST_TX_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !(tx_in_valid && tx_in_last)) |=> $stable(tx_lim)); // R8
endmodule

bind frame_len_policer flp_checker u_flp_checker (
  .clk(clk), .rst_n(rst_n),
  .rx_in_valid(rx_in_valid), .rx_in_last(rx_in_last),
  .rx_out_valid(rx_out_valid), .rx_out_last(rx_out_last), .rx_out_drop(rx_out_drop),
  .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last),
  .tx_out_valid(tx_out_valid), .tx_out_last(tx_out_last), .tx_out_drop(tx_out_drop),
  .err_irq(err_irq), .err_set(err_set), .err_clr(err_clr),
  .rx_busy(rx_busy), .tx_busy(tx_busy), .rx_lim(rx_lim), .tx_lim(tx_lim)
);

// File: tb/test_frame_len_policer.sv
module test_frame_len_policer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_in_valid = 1'b0, rx_in_last = 1'b0;
  logic [7:0]  rx_in_data = '0;
  logic        rx_out_valid, rx_out_last, rx_out_drop;
  logic [7:0]  rx_out_data;
  logic        tx_in_valid = 1'b0, tx_in_last = 1'b0;
  logic [7:0]  tx_in_data = '0;
  logic        tx_out_valid, tx_out_last, tx_out_drop;
  logic [7:0]  tx_out_data;
  logic        err_irq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  frame_len_policer i_frame_len_policer (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_in_valid(rx_in_valid), .rx_in_last(rx_in_last), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_last(rx_out_last), .rx_out_data(rx_out_data),
    .rx_out_drop(rx_out_drop),
    .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_last(tx_out_last), .tx_out_data(tx_out_data),
    .tx_out_drop(tx_out_drop), .err_irq(err_irq)
  );

  localparam logic [7:0] A_CFG = 8'h00, A_STAT = 8'h24, A_JMAX = 8'h48;

  // Output monitor, sampling away from the active edge.
  int  mon_beats;
  int  mon_drop_last;
  int  mon_drop_bad;
  int  mon_last_cnt;
  bit  mon_is_tx;
  always @(negedge clk) begin
    if (mon_is_tx ? tx_out_valid : rx_out_valid) begin
      mon_beats++;
      if (mon_is_tx ? tx_out_last : rx_out_last) begin
        mon_last_cnt++;
        if (mon_is_tx ? tx_out_drop : rx_out_drop) mon_drop_last++;
      end else if (mon_is_tx ? tx_out_drop : rx_out_drop) begin
        mon_drop_bad++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mon_clear(input bit tx);
    @(negedge clk);
    mon_is_tx = tx;
    mon_beats = 0; mon_drop_last = 0; mon_drop_bad = 0; mon_last_cnt = 0;
  endtask

  // Sends a frame; mid_at >= 0 writes mid_cfg to the configuration at that beat.
  task automatic send_frame(input bit tx, input int len, input int mid_at,
                            input logic [31:0] mid_cfg);
    mon_clear(tx);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (tx) begin
        tx_in_valid = 1'b1; tx_in_last = (i == len-1); tx_in_data = i[7:0];
      end else begin
        rx_in_valid = 1'b1; rx_in_last = (i == len-1); rx_in_data = i[7:0];
      end
      reg_wr_en = (i == mid_at); reg_addr = A_CFG; reg_wdata = mid_cfg;
    end
    @(negedge clk);
    tx_in_valid = 1'b0; tx_in_last = 1'b0;
    rx_in_valid = 1'b0; rx_in_last = 1'b0;
    reg_wr_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] jmax;
    logic        tx;
    logic [15:0] len;
    logic [15:0] lim;
    logic        drop;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0,   32'd10240,   1'b0, 16'd1518,  16'd1518,  1'b0}, // R2 R5 equal passes
    '{32'h0,   32'd10240,   1'b0, 16'd1519,  16'd1518,  1'b1}, // R2 R5 one over
    '{32'h100, 32'd10240,   1'b0, 16'd1538,  16'd1538,  1'b0}, // R2 bit 8
    '{32'h100, 32'd10240,   1'b0, 16'd1539,  16'd1538,  1'b1}, // R2
    '{32'h100, 32'd10240,   1'b1, 16'd1519,  16'd1518,  1'b1}, // R1 bit 8 ignored on tx
    '{32'h0,   32'd10240,   1'b1, 16'd1518,  16'd1518,  1'b0}, // R1
    '{32'h8,   32'd2000,    1'b0, 16'd2000,  16'd2000,  1'b0}, // R3
    '{32'h8,   32'd2000,    1'b0, 16'd2001,  16'd2000,  1'b1}, // R3
    '{32'h8,   32'd64,      1'b1, 16'd65,    16'd64,    1'b1}, // R3 R6
    '{32'h108, 32'd64,      1'b1, 16'd64,    16'd64,    1'b0}, // R3
    '{32'h8,   32'hFFFFFFFF,1'b0, 16'd10241, 16'd10240, 1'b1}, // R3 clamp
    '{32'h8,   32'hFFFFFFFF,1'b1, 16'd10240, 16'd10240, 1'b0}  // R3 clamp
  };

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int exp_beats;
    mon_is_tx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R4, R7)
    reg_read(A_JMAX, rd); chk(rd == 32'd10240, "R4 jumbo reset", rd, 10240);
    reg_read(A_CFG, rd);  chk(rd == 32'd0, "R4 cfg reset", rd, 0);
    reg_read(A_STAT, rd); chk(rd == 32'd0, "R7 status reset", rd, 0);
    chk(err_irq == 1'b0, "R7 irq reset", err_irq, 0);
    chk(rx_out_valid == 1'b0 && tx_out_valid == 1'b0, "R5 outputs idle at reset",
        rx_out_valid, 0);

    // Write masking (R4)
    reg_write(A_JMAX, 32'hFFFFFFFF);
    reg_read(A_JMAX, rd); chk(rd == 32'h3FFF, "R4 jumbo mask", rd, 32'h3FFF);
    reg_write(A_JMAX, 32'h0001_2345);
    reg_read(A_JMAX, rd); chk(rd == 32'h2345, "R4 jumbo low bits", rd, 32'h2345);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      reg_write(A_CFG, VECS[v].cfg);
      reg_write(A_JMAX, VECS[v].jmax);
      reg_write(A_STAT, 32'h40);
      send_frame(VECS[v].tx, int'(VECS[v].len), -1, 32'h0);
      exp_beats = (VECS[v].tx && VECS[v].drop) ? int'(VECS[v].lim) + 1 : int'(VECS[v].len);
      chk(mon_drop_last == int'(VECS[v].drop), $sformatf("R5 R1 R2 R3 drop vec %0d", v),
          mon_drop_last, int'(VECS[v].drop));
      chk(mon_beats == exp_beats, $sformatf("R6 R5 beat count vec %0d", v),
          mon_beats, exp_beats);
      chk(mon_drop_bad == 0 && mon_last_cnt == 1, $sformatf("R10 drop placement vec %0d", v),
          mon_drop_bad, 0);
      reg_read(A_STAT, rd);
      chk(rd[6] == VECS[v].drop, $sformatf("R7 error bit vec %0d", v),
          int'(rd[6]), int'(VECS[v].drop));
    end

    // Latency of one beat (R5)
    reg_write(A_CFG, 32'h0);
    @(negedge clk);
    rx_in_valid = 1'b1; rx_in_last = 1'b1; rx_in_data = 8'hA5;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_in_last = 1'b0;
    chk(rx_out_valid && rx_out_last && rx_out_data == 8'hA5 && !rx_out_drop,
        "R5 one clock latency", int'(rx_out_data), 32'hA5);

    // Mid-frame config change (R8), sticky bit and W1C (R7), restart (R9)
    reg_write(A_STAT, 32'h40);
    send_frame(1'b0, 1530, 10, 32'h100);
    chk(mon_drop_last == 1, "R8 limit captured at first beat", mon_drop_last, 1);
    send_frame(1'b0, 1530, -1, 32'h0);
    chk(mon_drop_last == 0, "R8 new mode on next frame", mon_drop_last, 0);
    chk(mon_beats == 1530, "R9 restart count", mon_beats, 1530);
    chk(err_irq == 1'b1, "R7 sticky after clean frame", err_irq, 1);
    reg_write(A_STAT, 32'hFFFFFFBF);
    chk(err_irq == 1'b1, "R7 write of zero keeps bit", err_irq, 1);
    reg_write(A_STAT, 32'h40);
    reg_read(A_STAT, rd);
    chk(rd[6] == 1'b0 && err_irq == 1'b0, "R7 write one clears", int'(rd[6]), 0);

    // Transmit truncation then recovery (R6, R9)
    reg_write(A_CFG, 32'h8);
    reg_write(A_JMAX, 32'd20);
    send_frame(1'b1, 40, -1, 32'h0);
    chk(mon_beats == 21 && mon_drop_last == 1, "R6 tx truncated", mon_beats, 21);
    send_frame(1'b1, 5, -1, 32'h0);
    chk(mon_beats == 5 && mon_drop_last == 0, "R9 tx after drop", mon_beats, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule